// File: doc/BRIEF.md
# Operand Bypass and Load-Use Interlock

This block holds the hazard logic of a five-stage in-order integer pipeline: fetch, decode with register read, execute, memory and write-back. The decode stage presents its two source register numbers, its destination, a write flag and a load flag. The block carries these control fields down the execute, memory and write-back stages on its own. From the fields held in the later stages it derives, for each execute operand, which value the operand multiplexer must take. It also decides when the instruction in decode has to wait for a load.

Every instruction that writes a register does so only from the write-back stage. ALU results travel through the memory stage unchanged, so the single write port never has two users in one cycle. The register file writes in the first half of a cycle and is read in the second. An instruction three slots behind a producer therefore sees the new value with no bypass, and only two bypass sources remain. A load followed at once by a consumer of its result raises a stall. The stall freezes the program counter and the fetch/decode register outside this block and puts exactly one empty slot into execute.

Top module: `bypass_stall_top`

## Requirements
- R1: `byp_a`/`byp_b` equal 1 (take the memory-stage result) when the execute operand's register matches the destination of a writing instruction in the memory stage.
- R2: `byp_a`/`byp_b` equal 2 (take the write-back-stage result) when the operand matches a writing instruction in write-back and not one in memory. Code 0 selects the register-file value.
- R3: When both the memory and write-back stages match the same operand, the select is 1.
- R4: Register 0 never produces a bypass select or a stall, and it always reads as zero even while a write to it is in write-back.
- R5: `stall` is high in the same cycle that decode presents a source register equal to the non-zero destination of a load in execute.
- R6: On the clock edge where `stall` is high, execute receives an empty slot. `ex_bubble` is high for the following cycle, and that slot never causes a bypass or a stall. One load causes exactly one stall cycle.
- R7: A read of the register being written from write-back in the same cycle returns `wb_wdata`.
- R8: A written value stays readable after the write-back cycle, whatever `wb_wdata` does later.
- R9: A destination is written only from write-back. Two cycles after the instruction leaves decode, a read of that register still returns the old contents.
- R10: After synchronous reset, `stall` and `ex_bubble` are low and both selects are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| id_rs1 | input | 5 | Decode-stage first source register |
| id_rs2 | input | 5 | Decode-stage second source register |
| id_rd | input | 5 | Decode-stage destination register |
| id_wen | input | 1 | Decode-stage instruction writes a register |
| id_load | input | 1 | Decode-stage instruction is a load |
| wb_wdata | input | 32 | Result value of the instruction in write-back |
| stall | output | 1 | Hold PC and fetch/decode register; empty slot to execute |
| ex_bubble | output | 1 | Execute stage holds an inserted empty slot |
| byp_a | output | 2 | Select for execute operand A (0 file, 1 memory, 2 write-back) |
| byp_b | output | 2 | Select for execute operand B (same encoding) |
| rf_rdata1 | output | 32 | Register-file value for `id_rs1` |
| rf_rdata2 | output | 32 | Register-file value for `id_rs2` |

## Verification
`stall` and the register-file read data depend on the decode inputs through logic only, so they are checked in the same cycle the inputs are applied. The bypass selects follow the instruction applied one edge earlier, compared against those applied two and three edges earlier. `ex_bubble` follows the stall by one edge. Each vector is driven just after the falling edge and sampled a moment later, before the next rising edge. The expected selects in each row are written for the stage contents the previous rows produced. For the register-file checks, the write counts as due on the third edge after the producer leaves decode.

// File: rtl/hzu_pkg.sv
package hzu_pkg;
    localparam int RIDX_W = 5;
    localparam int XLEN   = 32;
    localparam int NSRC   = 2;

    typedef logic [RIDX_W-1:0] ridx_t;

    typedef enum logic [1:0] {
        BYP_RF  = 2'd0,
        BYP_MEM = 2'd1,
        BYP_WB  = 2'd2
    } byp_sel_e;

    typedef struct packed {
        ridx_t rs1;
        ridx_t rs2;
        ridx_t rd;
        logic  wen;
        logic  load;
    } stage_ctl_t;

    function automatic logic dest_hits(input stage_ctl_t st, input ridx_t src);
        return st.wen && (st.rd != '0) && (st.rd == src);
    endfunction
endpackage

// File: rtl/hzu_stage_pipe.sv
module hzu_stage_pipe
    import hzu_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       stall_i,
    input  stage_ctl_t id_ctl_i,
    output stage_ctl_t ex_ctl_o,
    output stage_ctl_t mem_ctl_o,
    output stage_ctl_t wb_ctl_o,
    output logic       ex_bubble_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ex_ctl_o    <= '0;
            mem_ctl_o   <= '0;
            wb_ctl_o    <= '0;
            ex_bubble_o <= 1'b0;
        end else begin
            ex_ctl_o    <= stall_i ? '0 : id_ctl_i;
            mem_ctl_o   <= ex_ctl_o;
            wb_ctl_o    <= mem_ctl_o;
            ex_bubble_o <= stall_i;
        end
    end

    // R6: an inserted slot carries no write and no load
    p_bubble_inert_r6: assert property (@(posedge clk) disable iff (rst)
        ex_bubble_o |-> (!ex_ctl_o.wen && !ex_ctl_o.load));
endmodule

// File: rtl/hzu_bypass.sv
module hzu_bypass
    import hzu_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  stage_ctl_t ex_ctl_i,
    input  stage_ctl_t mem_ctl_i,
    input  stage_ctl_t wb_ctl_i,
    output byp_sel_e   sel_o [NSRC]
);
    ridx_t src [NSRC];
    assign src[0] = ex_ctl_i.rs1;
    assign src[1] = ex_ctl_i.rs2;

    for (genvar s = 0; s < NSRC; s++) begin : g_src
        always_comb begin
            if (dest_hits(mem_ctl_i, src[s]))
                sel_o[s] = BYP_MEM;
            else if (dest_hits(wb_ctl_i, src[s]))
                sel_o[s] = BYP_WB;
            else
                sel_o[s] = BYP_RF;
        end

        // R3: the older producer is never chosen over a matching younger one
        p_mem_first_r3: assert property (@(posedge clk) disable iff (rst)
            (sel_o[s] == BYP_WB) |-> !(mem_ctl_i.wen && mem_ctl_i.rd == src[s]
                                       && src[s] != '0));
        // R4: register 0 is never bypassed
        p_r0_no_byp_r4: assert property (@(posedge clk) disable iff (rst)
            (src[s] == '0) |-> (sel_o[s] == BYP_RF));
    end
endmodule

// File: rtl/hzu_load_use.sv
module hzu_load_use
    import hzu_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  stage_ctl_t ex_ctl_i,
    input  ridx_t      id_rs1_i,
    input  ridx_t      id_rs2_i,
    output logic       stall_o
);
    logic uses_load;
    assign uses_load = dest_hits(ex_ctl_i, id_rs1_i) || dest_hits(ex_ctl_i, id_rs2_i);
    assign stall_o   = ex_ctl_i.load && uses_load;

    // R4: a load aimed at register 0 never holds decode
    p_r0_no_stall_r4: assert property (@(posedge clk) disable iff (rst)
        (ex_ctl_i.rd == '0) |-> !stall_o);
endmodule

// File: rtl/hzu_regfile.sv
module hzu_regfile #(
    parameter int AW     = 5,
    parameter int DATA_W = 32,
    parameter int NRD    = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we_i,
    input  logic [AW-1:0]     waddr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [AW-1:0]     raddr_i [NRD],
    output logic [DATA_W-1:0] rdata_o [NRD]
);
    localparam int NREG = 1 << AW;

    logic [DATA_W-1:0] regs [NREG];
    logic              wr_live;
    assign wr_live = we_i && (waddr_i != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NREG; i++) regs[i] <= '0;
        end else if (wr_live) begin
            regs[waddr_i] <= wdata_i;
        end
    end

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        always_comb begin
            if (raddr_i[p] == '0)
                rdata_o[p] = '0;
            else if (wr_live && waddr_i == raddr_i[p])
                rdata_o[p] = wdata_i;
            else
                rdata_o[p] = regs[raddr_i[p]];
        end
    end

    // R8: a completed write is held in storage
    p_write_kept_r8: assert property (@(posedge clk) disable iff (rst)
        wr_live |=> (regs[$past(waddr_i)] == $past(wdata_i)));
    // R4: register 0 storage stays zero
    p_r0_zero_r4: assert property (@(posedge clk) disable iff (rst)
        regs[0] == '0);
endmodule

// File: rtl/bypass_stall_top.sv
module bypass_stall_top
    import hzu_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [4:0]      id_rs1,
    input  logic [4:0]      id_rs2,
    input  logic [4:0]      id_rd,
    input  logic            id_wen,
    input  logic            id_load,
    input  logic [XLEN-1:0] wb_wdata,
    output logic            stall,
    output logic            ex_bubble,
    output logic [1:0]      byp_a,
    output logic [1:0]      byp_b,
    output logic [XLEN-1:0] rf_rdata1,
    output logic [XLEN-1:0] rf_rdata2
);
    stage_ctl_t id_ctl, ex_ctl, mem_ctl, wb_ctl;
    byp_sel_e   sel [NSRC];
    ridx_t      rd_addr [NSRC];
    logic [XLEN-1:0] rd_data [NSRC];

    assign id_ctl = '{rs1: id_rs1, rs2: id_rs2, rd: id_rd, wen: id_wen, load: id_load};

    hzu_load_use u_load_use (
        .clk(clk), .rst(rst), .ex_ctl_i(ex_ctl),
        .id_rs1_i(id_rs1), .id_rs2_i(id_rs2), .stall_o(stall)
    );

    hzu_stage_pipe u_pipe (
        .clk(clk), .rst(rst), .stall_i(stall), .id_ctl_i(id_ctl),
        .ex_ctl_o(ex_ctl), .mem_ctl_o(mem_ctl), .wb_ctl_o(wb_ctl),
        .ex_bubble_o(ex_bubble)
    );

    hzu_bypass u_bypass (
        .clk(clk), .rst(rst), .ex_ctl_i(ex_ctl), .mem_ctl_i(mem_ctl),
        .wb_ctl_i(wb_ctl), .sel_o(sel)
    );

    assign rd_addr[0] = id_rs1;
    assign rd_addr[1] = id_rs2;

    hzu_regfile #(.AW(RIDX_W), .DATA_W(XLEN), .NRD(NSRC)) u_rf (
        .clk(clk), .rst(rst), .we_i(wb_ctl.wen), .waddr_i(wb_ctl.rd),
        .wdata_i(wb_wdata), .raddr_i(rd_addr), .rdata_o(rd_data)
    );

    assign byp_a     = sel[0];
    assign byp_b     = sel[1];
    assign rf_rdata1 = rd_data[0];
    assign rf_rdata2 = rd_data[1];

    // R6: one stall gives one empty slot and does not repeat
    p_single_bubble_r6: assert property (@(posedge clk) disable iff (rst)
        stall |=> (ex_bubble && !stall));
    // R5: a stall is only ever caused by a load, which then moves on to memory
    p_stall_by_load_r5: assert property (@(posedge clk) disable iff (rst)
        stall |=> mem_ctl.load);
    // R10: first cycle after reset is quiet
    p_reset_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!ex_bubble && byp_a == 2'd0 && byp_b == 2'd0));
endmodule

// File: tb/bypass_stall_top_tb_top.sv
module bypass_stall_top_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 23;

    logic        clk = 1'b0;
    logic        rst;
    logic [4:0]  id_rs1, id_rs2, id_rd;
    logic        id_wen, id_load;
    logic [31:0] wb_wdata;
    logic        stall, ex_bubble;
    logic [1:0]  byp_a, byp_b;
    logic [31:0] rf_rdata1, rf_rdata2;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bypass_stall_top dut_i (
        .clk(clk), .rst(rst), .id_rs1(id_rs1), .id_rs2(id_rs2), .id_rd(id_rd),
        .id_wen(id_wen), .id_load(id_load), .wb_wdata(wb_wdata),
        .stall(stall), .ex_bubble(ex_bubble), .byp_a(byp_a), .byp_b(byp_b),
        .rf_rdata1(rf_rdata1), .rf_rdata2(rf_rdata2)
    );

    // vector: rs1 rs2 rd wen load | stall bubble byp_a byp_b
    function automatic logic [22:0] mk(input int a, input int b, input int d,
                                       input int w, input int l, input int s,
                                       input int bb, input int fa, input int fb);
        return {5'(a), 5'(b), 5'(d), 1'(w), 1'(l), 1'(s), 1'(bb), 2'(fa), 2'(fb)};
    endfunction

    localparam logic [22:0] VEC [NVEC] = '{
        mk( 2, 3, 1,1,0, 0,0, 0,0),  // producer r1
        mk( 1, 3, 4,1,0, 0,0, 0,0),
        mk( 7, 1, 6,1,0, 0,0, 1,0),  // R1 on A
        mk( 1, 1, 8,1,0, 0,0, 0,2),  // R2 on B
        mk( 1, 9,10,1,0, 0,0, 0,0),  // third slot reads file
        mk( 3, 0, 2,1,1, 0,0, 0,0),  // load r2
        mk( 2, 2, 5,1,0, 1,0, 0,0),  // R5 load-use
        mk( 2, 2, 5,1,0, 0,1, 0,0),  // R6 held instr, bubble in EX
        mk( 0, 0, 0,0,0, 0,0, 2,2),  // load value from write-back
        mk( 0, 0, 3,1,0, 0,0, 0,0),
        mk( 0, 0, 3,1,0, 0,0, 0,0),
        mk( 3, 3, 9,1,0, 0,0, 0,0),
        mk( 0, 0, 0,0,0, 0,0, 1,1),  // R3 memory wins over write-back
        mk( 0, 0, 0,1,0, 0,0, 0,0),  // write to r0
        mk( 0, 0, 0,1,1, 0,0, 0,0),  // load to r0
        mk( 0, 0, 0,0,0, 0,0, 0,0),  // R4 no stall, no bypass on r0
        mk( 0, 0, 4,1,1, 0,0, 0,0),
        mk( 9, 4, 1,1,0, 1,0, 0,0),  // R5 via second source
        mk( 9, 4, 1,1,0, 0,1, 0,0),
        mk( 0, 0, 0,0,0, 0,0, 0,2),
        mk( 0, 0,11,1,1, 0,0, 0,0),
        mk(12,13,14,1,0, 0,0, 0,0),  // load with no consumer: no stall
        mk( 0, 0, 0,0,0, 0,0, 0,0)
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic drive(input int a, input int b, input int d, input int w, input int l);
        @(negedge clk);
        id_rs1 = 5'(a); id_rs2 = 5'(b); id_rd = 5'(d);
        id_wen = 1'(w); id_load = 1'(l);
        #1;
    endtask

    initial begin
        rst = 1'b1;
        id_rs1 = '0; id_rs2 = '0; id_rd = '0; id_wen = 1'b0; id_load = 1'b0;
        wb_wdata = 32'h0;
        repeat (2) @(posedge clk);
        @(negedge clk); rst = 1'b0; #1;
        // R10: reset state
        chk("R10 stall", 32'(stall), 0);
        chk("R10 ex_bubble", 32'(ex_bubble), 0);
        chk("R10 byp_a", 32'(byp_a), 0);
        chk("R10 byp_b", 32'(byp_b), 0);

        for (int k = 0; k < NVEC; k++) begin
            logic [22:0] v;
            v = VEC[k];
            drive(int'(v[22:18]), int'(v[17:13]), int'(v[12:8]), int'(v[7]), int'(v[6]));
            chk($sformatf("R5 stall vec%0d", k), 32'(stall), 32'(v[5]));
            chk($sformatf("R6 ex_bubble vec%0d", k), 32'(ex_bubble), 32'(v[4]));
            chk($sformatf("R1 R2 R3 R4 byp_a vec%0d", k), 32'(byp_a), 32'(v[3:2]));
            chk($sformatf("R1 R2 R3 R4 byp_b vec%0d", k), 32'(byp_b), 32'(v[1:0]));
        end

        // register-file timing
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        wb_wdata = 32'hCAFE_0005;
        drive(0, 0, 5, 1, 0);   // writer of r5 leaves decode at next edge
        drive(0, 0, 0, 0, 0);
        drive(5, 0, 0, 0, 0);   // writer in memory stage
        chk("R9 r5 not yet written", rf_rdata1, 32'h0);
        drive(5, 5, 0, 0, 0);   // writer in write-back
        chk("R7 write-first port1", rf_rdata1, 32'hCAFE_0005);
        chk("R7 write-first port2", rf_rdata2, 32'hCAFE_0005);
        drive(5, 0, 0, 0, 0);
        wb_wdata = 32'h1234_5678; #1;
        chk("R8 r5 retained", rf_rdata1, 32'hCAFE_0005);
        // R4: write to r0 reaching write-back reads as zero
        drive(0, 0, 0, 1, 0);
        drive(0, 0, 0, 0, 0);
        drive(0, 0, 0, 0, 0);
        drive(0, 0, 0, 0, 0);
        chk("R4 r0 read while written", rf_rdata2, 32'h0);
        drive(0, 0, 0, 0, 0);
        chk("R4 r0 read after write", rf_rdata1, 32'h0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule